// File: doc/BRIEF.md
# Audio Delay Line SRAM Sequencer

This block delays a stream of audio samples by a fixed number of sample periods, using an external asynchronous static RAM as the storage. A single address counter serves both directions. When a new converter sample arrives, the sequencer reads the word stored at the current address and presents it on the playback output. It then writes the new sample into that same location and moves the counter on by one. The delay is therefore the wrap period of the counter, which is `2**ADDR_W` samples.

The memory has no clock, so the sequencer frames every access with active-low chip-select, write-strobe and read-enable signals that it decodes from its slot state. A read slot is followed by a bus turnaround cycle, then a write-strobe cycle and a recovery cycle, so a new sample can be taken every five clocks. With `ADDR_W = 13` and a 40.96 kHz sample rate, the delay is one fifth of a second. During the first pass through the memory, the stored words are stale, so the playback output is held at zero until the counter has wrapped once.

Top module: `audio_delay_seq`

## Requirements
- R1: After reset the address is 0, `mem_cs_n`, `mem_we_n` and `mem_oe_n` are all 1, and `play_valid` is 0.
- R2: The cycle after the edge that accepts `smp_valid` is a read slot. In it, `mem_cs_n`=0, `mem_oe_n`=0, `mem_we_n`=1, and the block does not drive `mem_dq`.
- R3: The read slot is followed by one turnaround cycle and then one cycle with `mem_we_n`=0. In the turnaround cycle `mem_oe_n`=1, `mem_we_n`=1, and `mem_dq` carries the accepted sample. In the `mem_we_n`=0 cycle, `mem_oe_n` is 1 and `mem_dq` still carries the sample. After that comes one recovery cycle with `mem_we_n`=1.
- R4: The read and the write of one sample use the same address. The address rises by one only at the edge that ends the recovery cycle. It wraps from `2**ADDR_W-1` to 0.
- R5: `play_valid` is 1 for exactly one cycle. That cycle starts at the second rising edge after the accepting edge. `play_data` then holds the word read in the read slot.
- R6: Until the address has wrapped once after reset, every `play_data` word given with `play_valid` is 0, whatever the memory holds.
- R7: Once the address has wrapped, sample number n (counting from 0 after reset) is played as input sample n-`2**ADDR_W`.
- R8: `smp_valid` is ignored while a sample sequence is in progress. It does not alter the stored data, the address or the number of `play_valid` pulses.
- R9: The block returns to idle with all strobes at 1 in the cycle after recovery. A sample can be accepted every five cycles, and while idle the strobes stay at 1 and `play_valid` stays at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Base clock |
| rst_n | input | 1 | Active-low synchronous reset |
| smp_data | input | DATA_W | Incoming converter sample |
| smp_valid | input | 1 | Strobe marking a new sample |
| play_data | output | DATA_W | Delayed sample for playback |
| play_valid | output | 1 | One-cycle strobe marking play_data |
| mem_addr | output | ADDR_W | Memory address |
| mem_dq | inout | DATA_W | Bidirectional memory data bus |
| mem_cs_n | output | 1 | Memory chip select, active low |
| mem_we_n | output | 1 | Memory write strobe, active low |
| mem_oe_n | output | 1 | Memory read enable, active low |

## Verification
Two events can fall in the same cycle: a fresh `smp_valid` strobe arriving while a sample is still being sequenced, and the counter wrap that ends the zeroing pass. The bench uses an eight-entry memory. It raises `smp_valid` again during read slots with different data, and it runs samples both back to back and with idle gaps over several full wraps. Each delayed word is compared with the sample sent `2**ADDR_W` periods earlier, or with zero during the first pass. Any stray acceptance would show up as a wrong word one lap later or as an extra address step.

// File: rtl/audio_dly_pkg.sv
package audio_dly_pkg;
  typedef enum logic [2:0] {
    SL_IDLE  = 3'd0,
    SL_READ  = 3'd1,
    SL_TURN  = 3'd2,
    SL_WRITE = 3'd3,
    SL_RECOV = 3'd4
  } slot_e;

  // address step with wrap to zero at depth
  function automatic int unsigned wrap_inc(input int unsigned a, input int unsigned depth);
    return (a + 1 >= depth) ? 0 : a + 1;
  endfunction
endpackage

// File: rtl/dly_addr_ctr.sv
module dly_addr_ctr #(
  parameter int unsigned ADDR_W = 13
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              step,
  output logic [ADDR_W-1:0] addr,
  output logic              primed
);
  import audio_dly_pkg::*;
  localparam int unsigned DEPTH = 1 << ADDR_W;

  logic [ADDR_W-1:0] addr_q;
  logic              primed_q;
  logic              wrap_evt;

  assign wrap_evt = step && (32'(addr_q) == DEPTH - 1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      addr_q   <= '0;
      primed_q <= 1'b0;
    end else begin
      if (step) addr_q <= ADDR_W'(wrap_inc(32'(addr_q), DEPTH));
      if (wrap_evt) primed_q <= 1'b1;
    end
  end

  assign addr   = addr_q;
  assign primed = primed_q;

  // R4
  addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_q != $past(addr_q)) |-> (32'(addr_q) == wrap_inc(32'($past(addr_q)), DEPTH)));
  // R6
  primed_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(primed_q) |-> primed_q);
endmodule

// File: rtl/dly_slot_fsm.sv
module dly_slot_fsm (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic accept,
  output logic cap_evt,
  output logic drive_en,
  output logic step,
  output logic play_valid,
  output logic cs_n,
  output logic we_n,
  output logic oe_n
);
  import audio_dly_pkg::*;

  slot_e st_q, st_d;
  logic  pv_q;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      SL_IDLE:  if (start) st_d = SL_READ;
      SL_READ:  st_d = SL_TURN;
      SL_TURN:  st_d = SL_WRITE;
      SL_WRITE: st_d = SL_RECOV;
      SL_RECOV: st_d = SL_IDLE;
      default:  st_d = SL_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q <= SL_IDLE;
      pv_q <= 1'b0;
    end else begin
      st_q <= st_d;
      pv_q <= (st_q == SL_TURN);
    end
  end

  assign accept     = (st_q == SL_IDLE) && start;
  assign cap_evt    = (st_q == SL_READ);
  assign drive_en   = (st_q == SL_TURN) || (st_q == SL_WRITE) || (st_q == SL_RECOV);
  assign step       = (st_q == SL_RECOV);
  assign play_valid = pv_q;
  assign cs_n       = (st_q == SL_IDLE);
  assign oe_n       = (st_q != SL_READ);
  assign we_n       = (st_q != SL_WRITE);

  // R3
  we_after_oe_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(we_n) |-> ($past(oe_n) && oe_n && drive_en));
  // R2
  read_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !oe_n |-> (!cs_n && we_n && !drive_en));
  // R5
  play_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    play_valid |=> !play_valid);
  // R8
  no_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_n && start) |=> !(cap_evt && $past(!cs_n) && !$past(step)));
endmodule

// File: rtl/dly_bus_io.sv
module dly_bus_io #(
  parameter int unsigned DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [DATA_W-1:0] in_data,
  input  logic              cap_evt,
  input  logic              primed,
  input  logic              drive_en,
  inout  wire  [DATA_W-1:0] dq,
  output logic [DATA_W-1:0] out_data
);
  logic [DATA_W-1:0] wr_q;
  logic [DATA_W-1:0] rd_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_q <= '0;
      rd_q <= '0;
    end else begin
      if (load) wr_q <= in_data;
      if (cap_evt) rd_q <= primed ? dq : '0;
    end
  end

  assign dq       = drive_en ? wr_q : {DATA_W{1'bz}};
  assign out_data = rd_q;

  // R3
  wdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (drive_en && $past(drive_en)) |-> $stable(wr_q));
endmodule

// File: rtl/audio_delay_seq.sv
module audio_delay_seq #(
  parameter int unsigned ADDR_W = 13,
  parameter int unsigned DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] smp_data,
  input  logic              smp_valid,
  output logic [DATA_W-1:0] play_data,
  output logic              play_valid,
  output logic [ADDR_W-1:0] mem_addr,
  inout  wire  [DATA_W-1:0] mem_dq,
  output logic              mem_cs_n,
  output logic              mem_we_n,
  output logic              mem_oe_n
);
  logic accept, cap_evt, drive_en, step, primed;

  dly_slot_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .start(smp_valid), .accept(accept),
    .cap_evt(cap_evt), .drive_en(drive_en), .step(step),
    .play_valid(play_valid), .cs_n(mem_cs_n), .we_n(mem_we_n), .oe_n(mem_oe_n)
  );

  dly_addr_ctr #(.ADDR_W(ADDR_W)) u_ctr (
    .clk(clk), .rst_n(rst_n), .step(step), .addr(mem_addr), .primed(primed)
  );

  dly_bus_io #(.DATA_W(DATA_W)) u_io (
    .clk(clk), .rst_n(rst_n), .load(accept), .in_data(smp_data),
    .cap_evt(cap_evt), .primed(primed), .drive_en(drive_en),
    .dq(mem_dq), .out_data(play_data)
  );

  // R3
  addr_hold_we_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_we_n |-> $stable(mem_addr));
  // R4
  addr_only_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_addr != $past(mem_addr)) |-> mem_cs_n);
  // R6
  zero_first_lap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (play_valid && !primed) |-> (play_data == '0));
endmodule

// File: tb/audio_delay_seq_bench.sv
module audio_delay_seq_bench;
  localparam int AW = 3;
  localparam int DW = 16;
  localparam int DEPTH = 1 << AW;
  localparam int NSMP = 5 * DEPTH + 3;

  logic clk = 0;
  logic rst_n = 0;
  logic [DW-1:0] smp_data = '0;
  logic smp_valid = 0;
  logic [DW-1:0] play_data;
  logic play_valid;
  logic [AW-1:0] mem_addr;
  wire  [DW-1:0] mem_dq;
  logic mem_cs_n, mem_we_n, mem_oe_n;

  int n_chk = 0;
  int n_bad = 0;
  logic [DW-1:0] mem [DEPTH];
  logic [DW-1:0] hist [NSMP];

  always #2.5 clk = ~clk;

  audio_delay_seq #(.ADDR_W(AW), .DATA_W(DW)) u_audio_delay_seq (
    .clk(clk), .rst_n(rst_n), .smp_data(smp_data), .smp_valid(smp_valid),
    .play_data(play_data), .play_valid(play_valid), .mem_addr(mem_addr),
    .mem_dq(mem_dq), .mem_cs_n(mem_cs_n), .mem_we_n(mem_we_n), .mem_oe_n(mem_oe_n)
  );

  // memory model: stale non-zero contents at reset
  assign mem_dq = (!mem_cs_n && !mem_oe_n && mem_we_n) ? mem[mem_addr] : {DW{1'bz}};
  always @(negedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= 16'hBEEF ^ 16'(i);
    end else if (!mem_cs_n && !mem_we_n) begin
      mem[mem_addr] <= mem_dq;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic run_sample(input int n, input bit poke);
    logic [DW-1:0] v;
    logic [AW-1:0] a0;
    logic [DW-1:0] exp;
    v = 16'(n * 16'h1357 + 16'h00A1);
    hist[n] = v;
    exp = (n >= DEPTH) ? hist[n - DEPTH] : '0;
    a0 = mem_addr;
    chk("R4 start addr", 32'(a0), 32'(n % DEPTH));
    smp_valid = 1; smp_data = v;
    @(negedge clk);
    // read slot
    smp_valid = poke; smp_data = ~v;
    chk("R2 read strobes", {mem_cs_n, mem_oe_n, mem_we_n}, 3'b001);
    chk("R4 read addr", 32'(mem_addr), 32'(a0));
    @(negedge clk);
    // turnaround
    smp_valid = 0;
    chk("R3 turn strobes", {mem_cs_n, mem_oe_n, mem_we_n}, 3'b011);
    chk("R3 turn data", 32'(mem_dq), 32'(v));
    chk("R5 no early valid", 32'(play_valid), 0);
    @(negedge clk);
    // write strobe
    chk("R3 write strobes", {mem_cs_n, mem_oe_n, mem_we_n}, 3'b010);
    chk("R3 write data", 32'(mem_dq), 32'(v));
    chk("R4 write addr", 32'(mem_addr), 32'(a0));
    chk("R5 valid", 32'(play_valid), 1);
    if (n < DEPTH) chk("R6 zero first lap", 32'(play_data), 0);
    else chk("R7 delayed word", 32'(play_data), 32'(exp));
    @(negedge clk);
    // recovery
    chk("R3 recovery strobes", {mem_cs_n, mem_oe_n, mem_we_n}, 3'b011);
    chk("R5 single pulse", 32'(play_valid), 0);
    chk("R4 addr held in recovery", 32'(mem_addr), 32'(a0));
    @(negedge clk);
    // idle
    chk("R9 idle strobes", {mem_cs_n, mem_oe_n, mem_we_n}, 3'b111);
    chk("R4 addr step", 32'(mem_addr), 32'((n + 1) % DEPTH));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1 reset strobes", {mem_cs_n, mem_oe_n, mem_we_n}, 3'b111);
    chk("R1 reset addr", 32'(mem_addr), 0);
    chk("R1 reset valid", 32'(play_valid), 0);
    for (int n = 0; n < NSMP; n++) begin
      run_sample(n, (n % 3) == 1);
      if ((n % 4) == 2) begin
        for (int g = 0; g < (n % 5) + 1; g++) begin
          @(negedge clk);
          chk("R9 idle hold", {play_valid, mem_cs_n, mem_we_n, mem_oe_n}, 4'b0111);
        end
      end
    end
    chk("R8 stored words unaffected", 32'(mem[(NSMP - 1) % DEPTH]), 32'(hist[NSMP - 1]));
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule